// File: doc/BRIEF.md
# Flash Self-Programming Write Controller

This block lets a processor rewrite its own program flash through a small set of byte-wide registers. Firmware writes a word address, a 14-bit data word and a control byte. Every operation must be preceded by a two-byte unlock key. The controller holds a bank of write latches that covers one aligned block of program words. A keyed start can do one of three things: store one word into a latch, store the final word and then commit the whole latch bank to flash, or erase one aligned row.

Block writes and row erases run in fixed phases. There are a short setup phase, then a timed program or erase phase, then a one-cycle commit pulse to the flash array. The array is modelled outside the block. It takes a pulse, an erase flag, a base address and the full latch image. During the timed phase the controller raises a stall output so that the processor stops fetching. Clocks and the rest of the chip keep running. The timed length is a parameter, so simulation can use a short count.

Top module: `flash_selfprog_ctrl`

## Requirements
- R1: After reset, every register reads 0x00 on `reg_rdata`, and `cpu_stall`, `op_done` and `fl_we` are low. The key register (select 5) always reads 0x00.
- R2: A start is accepted only when three register writes come in a row: 0x55 to the key register, then 0xAA to the key register, then a control write (select 4) with start (bit 0), write enable (bit 1) and program-memory select (bit 4) all set. Idle cycles between these writes are allowed. A mismatched byte, an out-of-order byte or any other register write in between voids the sequence. A start with bits 1 and 4 set but without the key does nothing and sets the key-error flag (control bit 5). The next accepted start clears that flag.
- R3: A start with write enable 0 or program-memory select 0 is ignored, even when it is keyed, and it leaves the key-error flag unchanged.
- R4: A keyed start with latch-only (bit 3) set and erase (bit 2) clear stores the data register into the latch selected by the low 4 address bits. No flash operation is issued. `op_done` pulses one cycle later, and start reads back 0.
- R5: A keyed start with latch-only and erase clear stores the final word and then issues one flash write. Its base is the address with the low 4 bits cleared. `fl_data` word j (bits 14j+13:14j) holds latch j, and latches that were never loaded hold 0x3FFF.
- R6: After a block write commits, every latch holds 0x3FFF.
- R7: A keyed start with erase set issues a flash erase of the 32-word row that contains the address. The erase bit reads 1 while the erase runs and 0 from the done cycle on.
- R8: After an accepted block write or erase, `cpu_stall` stays low for 2 cycles and then stays high for PROG_CYCLES cycles. In the next cycle `fl_we` and `op_done` pulse for one cycle, and start reads back 0.
- R9: Register writes made while an operation is running change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select: 0/1 address low/high, 2/3 data low/high, 4 control, 5 key |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Read-back of the selected register |
| cpu_stall | output | 1 | High while the timed program or erase phase runs |
| op_done | output | 1 | One-cycle pulse at the end of each accepted operation |
| fl_we | output | 1 | One-cycle commit pulse to the flash array |
| fl_erase | output | 1 | With `fl_we`: 1 means row erase, 0 means block program |
| fl_addr | output | ADDR_W | Aligned base address of the block or row |
| fl_data | output | LATCHES*14 | Latch image, word j in bits 14j+13:14j |

## Verification
The assertions assume that reset is held across at least one clock edge. They also assume that the processor issues no register writes while the stall is high, except for the deliberate writes made to check R9. The interface itself does not prevent such writes. The bench drives every register write half a cycle away from the active edge. It never overlaps a latch load with a commit, because a key sequence cannot be completed while an operation is running. The near-exhaustive sweep writes one word into each latch index in turn. It computes the expected flash image arithmetically from a shadow of the latches.

// File: rtl/fsp_pkg.sv
// Shared constants and state types for the flash self-programming controller.
// Assumes 14-bit program words and byte-wide register access.
package fsp_pkg;
    localparam int WORD_W = 14;
    localparam logic [WORD_W-1:0] WORD_ONES = '1;

    localparam logic [2:0] SEL_ADDR_LO = 3'd0;
    localparam logic [2:0] SEL_ADDR_HI = 3'd1;
    localparam logic [2:0] SEL_DATA_LO = 3'd2;
    localparam logic [2:0] SEL_DATA_HI = 3'd3;
    localparam logic [2:0] SEL_CTRL    = 3'd4;
    localparam logic [2:0] SEL_KEY     = 3'd5;

    localparam int CB_START = 0;
    localparam int CB_WEN   = 1;
    localparam int CB_ERASE = 2;
    localparam int CB_LONLY = 3;
    localparam int CB_PMEM  = 4;
    localparam int CB_KERR  = 5;

    localparam logic [7:0] KEY_FIRST  = 8'h55;
    localparam logic [7:0] KEY_SECOND = 8'hAA;

    typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_BUSY} seq_state_t;
    typedef enum logic [1:0] {KU_IDLE, KU_HALF, KU_ARMED} key_state_t;
endpackage

// File: rtl/fsp_key_unlock.sv
// Unlock tracker: follows the two-byte key on the register bus.
// Assumes acc pulses once per register write; key_acc marks a write to the
// key register that is allowed to count (no operation running).
module fsp_key_unlock
    import fsp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       acc,
    input  logic       key_acc,
    input  logic [7:0] wdata,
    output logic       armed
);
    key_state_t st;

    // Advance on the expected byte; any other register write drops to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= KU_IDLE;
        end else if (acc) begin
            if (key_acc && wdata == KEY_FIRST)
                st <= KU_HALF;
            else if (key_acc && wdata == KEY_SECOND && st == KU_HALF)
                st <= KU_ARMED;
            else
                st <= KU_IDLE;
        end
    end

    assign armed = (st == KU_ARMED);

    // R2: the unlock is consumed by whatever register write follows it.
    p_armed_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && acc) |=> !armed);
endmodule

// File: rtl/fsp_latch_bank.sv
// Bank of N program-word write latches.
// Assumes load and clear are never asserted together; clear presets all to ones.
module fsp_latch_bank
    import fsp_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [$clog2(N)-1:0]  idx,
    input  logic [WORD_W-1:0]     word,
    input  logic                  clear,
    output logic [N*WORD_W-1:0]   flat
);
    localparam int IDX_W = $clog2(N);

    for (genvar g = 0; g < N; g++) begin : g_lat
        logic [WORD_W-1:0] q;

        // Hold one word: preset on reset or commit, capture on a matching load.
        always_ff @(posedge clk) begin
            if (!rst_n || clear)
                q <= WORD_ONES;
            else if (load && idx == IDX_W'(g))
                q <= word;
        end

        assign flat[g*WORD_W +: WORD_W] = q;
    end

    // R6: a commit leaves every latch erased-state ones.
    p_ones_after_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (flat == '1));
endmodule

// File: rtl/fsp_op_sequencer.sv
// Timing sequencer for block writes and row erases: a setup phase, then a
// stalled program phase of PROG_CYCLES, then a registered finish pulse.
// Assumes go is only raised while idle and SETUP_CYCLES >= 1.
module fsp_op_sequencer
    import fsp_pkg::*;
#(
    parameter int SETUP_CYCLES = 2,
    parameter int PROG_CYCLES  = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic active,
    output logic stall,
    output logic ending,
    output logic fin
);
    localparam int MAXC  = (PROG_CYCLES > SETUP_CYCLES) ? PROG_CYCLES : SETUP_CYCLES;
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam logic [CNT_W-1:0] LAST_S = CNT_W'(SETUP_CYCLES - 1);
    localparam logic [CNT_W-1:0] LAST_P = CNT_W'(PROG_CYCLES - 1);

    seq_state_t       st;
    logic [CNT_W-1:0] cnt;

    // Phase state and cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= SQ_IDLE;
            cnt <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (go) begin
                    st  <= SQ_SETUP;
                    cnt <= '0;
                end
                SQ_SETUP: if (cnt == LAST_S) begin
                    st  <= SQ_BUSY;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                SQ_BUSY: if (cnt == LAST_P) begin
                    st  <= SQ_IDLE;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Registered end-of-operation pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) fin <= 1'b0;
        else        fin <= ending;
    end

    assign active = (st != SQ_IDLE);
    assign stall  = (st == SQ_BUSY);
    assign ending = (st == SQ_BUSY) && (cnt == LAST_P);

    // R8: the finish pulse lasts one cycle.
    p_fin_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);
    // R8: stall only begins after the setup phase.
    p_stall_after_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(st == SQ_SETUP));
endmodule

// File: rtl/flash_selfprog_ctrl.sv
// Flash self-programming write controller: register file, key gating,
// write latches and operation sequencing toward an external flash array.
// Assumes the processor honours cpu_stall; writes during an operation are dropped.
module flash_selfprog_ctrl
    import fsp_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int LATCHES      = 16,
    parameter int ROW_WORDS    = 32,
    parameter int SETUP_CYCLES = 2,
    parameter int PROG_CYCLES  = 4000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       reg_we,
    input  logic [2:0]                 reg_sel,
    input  logic [7:0]                 reg_wdata,
    output logic [7:0]                 reg_rdata,
    output logic                       cpu_stall,
    output logic                       op_done,
    output logic                       fl_we,
    output logic                       fl_erase,
    output logic [ADDR_W-1:0]          fl_addr,
    output logic [LATCHES*WORD_W-1:0]  fl_data
);
    localparam int IDX_W = $clog2(LATCHES);
    localparam int HI_W  = ADDR_W - 8;
    localparam logic [ADDR_W-1:0] BLK_MASK = ~ADDR_W'(LATCHES - 1);
    localparam logic [ADDR_W-1:0] ROW_MASK = ~ADDR_W'(ROW_WORDS - 1);

    logic [ADDR_W-1:0] addr_q;
    logic [WORD_W-1:0] data_q;
    logic start_q, wen_q, erase_q, lonly_q, pmem_q, kerr_q;
    logic op_erase_q, latch_done_q;
    logic [ADDR_W-1:0] op_base_q;

    logic busy, seq_ending, seq_fin, armed;
    logic wr_ok, start_wr, go_ok, accept, refuse, long_op, lat_load, lat_clear;

    assign wr_ok    = reg_we && !busy;
    assign start_wr = wr_ok && reg_sel == SEL_CTRL && reg_wdata[CB_START];
    assign go_ok    = start_wr && reg_wdata[CB_WEN] && reg_wdata[CB_PMEM];
    assign accept   = go_ok && armed;
    assign refuse   = go_ok && !armed;
    assign long_op  = reg_wdata[CB_ERASE] || !reg_wdata[CB_LONLY];
    assign lat_load = accept && !reg_wdata[CB_ERASE];
    assign lat_clear = seq_fin && !op_erase_q;

    fsp_key_unlock u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc     (reg_we),
        .key_acc (reg_sel == SEL_KEY && !busy),
        .wdata   (reg_wdata),
        .armed   (armed)
    );

    fsp_latch_bank #(.N(LATCHES)) u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (lat_load),
        .idx   (addr_q[IDX_W-1:0]),
        .word  (data_q),
        .clear (lat_clear),
        .flat  (fl_data)
    );

    fsp_op_sequencer #(.SETUP_CYCLES(SETUP_CYCLES), .PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (accept && long_op),
        .active (busy),
        .stall  (cpu_stall),
        .ending (seq_ending),
        .fin    (seq_fin)
    );

    // Register file writes, control-bit updates and end-of-operation clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            data_q  <= '0;
            start_q <= 1'b0;
            wen_q   <= 1'b0;
            erase_q <= 1'b0;
            lonly_q <= 1'b0;
            pmem_q  <= 1'b0;
            kerr_q  <= 1'b0;
        end else begin
            if (wr_ok) begin
                case (reg_sel)
                    SEL_ADDR_LO: addr_q[7:0] <= reg_wdata;
                    SEL_ADDR_HI: addr_q[ADDR_W-1:8] <= reg_wdata[HI_W-1:0];
                    SEL_DATA_LO: data_q[7:0] <= reg_wdata;
                    SEL_DATA_HI: data_q[WORD_W-1:8] <= reg_wdata[WORD_W-9:0];
                    SEL_CTRL: begin
                        wen_q   <= reg_wdata[CB_WEN];
                        erase_q <= reg_wdata[CB_ERASE];
                        lonly_q <= reg_wdata[CB_LONLY];
                        pmem_q  <= reg_wdata[CB_PMEM];
                        start_q <= accept && long_op;
                    end
                    default: ;
                endcase
            end
            if (accept)      kerr_q <= 1'b0;
            else if (refuse) kerr_q <= 1'b1;
            if (seq_ending) begin
                start_q <= 1'b0;
                erase_q <= 1'b0;
            end
        end
    end

    // Operation descriptor captured at an accepted start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_erase_q   <= 1'b0;
            op_base_q    <= '0;
            latch_done_q <= 1'b0;
        end else begin
            latch_done_q <= accept && !long_op;
            if (accept && long_op) begin
                op_erase_q <= reg_wdata[CB_ERASE];
                op_base_q  <= reg_wdata[CB_ERASE] ? (addr_q & ROW_MASK) : (addr_q & BLK_MASK);
            end
        end
    end

    // Read-back multiplexer; the key register reads as zero.
    always_comb begin
        case (reg_sel)
            SEL_ADDR_LO: reg_rdata = addr_q[7:0];
            SEL_ADDR_HI: reg_rdata = 8'(addr_q[ADDR_W-1:8]);
            SEL_DATA_LO: reg_rdata = data_q[7:0];
            SEL_DATA_HI: reg_rdata = 8'(data_q[WORD_W-1:8]);
            SEL_CTRL:    reg_rdata = {2'b00, kerr_q, pmem_q, lonly_q, erase_q, wen_q, start_q};
            default:     reg_rdata = 8'h00;
        endcase
    end

    assign op_done  = latch_done_q || seq_fin;
    assign fl_we    = seq_fin;
    assign fl_erase = seq_fin && op_erase_q;
    assign fl_addr  = op_base_q;

    // R9: writes arriving during the stall leave the registers untouched.
    p_busy_ignores_regs_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_stall && reg_we) |=> ($stable(addr_q) && $stable(data_q)));
    // R8: the start bit has cleared by the time done is reported.
    p_start_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |-> !start_q);
    // R8: a flash commit only follows the stalled program phase.
    p_flash_after_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fl_we |-> $past(cpu_stall));
endmodule

// File: tb/tb_flash_selfprog_ctrl.sv
`timescale 1ns/1ps
module tb_flash_selfprog_ctrl;
    localparam int AW   = 10;
    localparam int NL   = 16;
    localparam int ROWW = 32;
    localparam int P    = 8;
    localparam int WW   = 14;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_we = 1'b0;
    logic [2:0] reg_sel = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic cpu_stall, op_done, fl_we, fl_erase;
    logic [AW-1:0] fl_addr;
    logic [NL*WW-1:0] fl_data;

    int n_chk = 0;
    int n_fail = 0;
    int mem [1024];
    int exp_mem [1024];
    int lat_exp [NL];
    int flash_events = 0;
    logic [NL*WW-1:0] cap_data;

    always #4 clk = ~clk;

    flash_selfprog_ctrl #(.ADDR_W(AW), .LATCHES(NL), .ROW_WORDS(ROWW),
                          .SETUP_CYCLES(2), .PROG_CYCLES(P)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_stall(cpu_stall),
        .op_done(op_done), .fl_we(fl_we), .fl_erase(fl_erase),
        .fl_addr(fl_addr), .fl_data(fl_data)
    );

    // Flash array model: applies commits away from the active edge.
    always @(negedge clk) begin
        if (rst_n && fl_we) begin
            flash_events++;
            cap_data = fl_data;
            if (fl_erase)
                for (int j = 0; j < ROWW; j++) mem[int'(fl_addr) + j] = 'h3FFF;
            else
                for (int j = 0; j < NL; j++) mem[int'(fl_addr) + j] = int'(fl_data[j*WW +: WW]);
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] d);
        reg_sel = s;
        #1;
        d = reg_rdata;
    endtask

    task automatic set_addr(input int a);
        wr(3'd0, 8'(a));
        wr(3'd1, 8'(a >> 8));
    endtask

    task automatic set_data(input int d);
        wr(3'd2, 8'(d));
        wr(3'd3, 8'(d >> 8));
    endtask

    task automatic keyed(input logic [7:0] c);
        wr(3'd5, 8'h55);
        wr(3'd5, 8'hAA);
        wr(3'd4, c);
    endtask

    task automatic cmp_mem(input string req);
        int bad = 0;
        int first = 0;
        for (int i = 0; i < 1024; i++)
            if (mem[i] != exp_mem[i]) begin
                if (bad == 0) first = i;
                bad++;
            end
        check(bad == 0, req, mem[first], exp_mem[first]);
    endtask

    // Follow a long operation from the cycle after the start write to done.
    task automatic run_long(input string req, input bit er, input int base);
        int pre = 0;
        int st = 0;
        int guard = 0;
        bit er_seen = 1'b1;
        logic [7:0] v;
        while (!op_done && guard < 200) begin
            if (cpu_stall) begin
                st++;
                if (er && st == 1) begin rd(3'd4, v); er_seen = v[2]; end
            end else if (st == 0) begin
                pre++;
            end
            guard++;
            @(negedge clk);
        end
        check(pre == 2, {req, " R8 setup cycles"}, pre, 2);
        check(st == P, {req, " R8 stall cycles"}, st, P);
        check(fl_we == 1'b1 && fl_erase == er, {req, " R8 commit pulse"}, {fl_we, fl_erase}, {1'b1, er});
        check(int'(fl_addr) == base, {req, " base address"}, int'(fl_addr), base);
        rd(3'd4, v);
        check(v[0] == 1'b0, {req, " R8 start cleared"}, v[0], 0);
        if (er) begin
            check(er_seen, "R7 erase bit high while running", er_seen, 1);
            check(v[2] == 1'b0, "R7 erase bit cleared at done", v[2], 0);
        end
        @(negedge clk);
        check(op_done == 1'b0 && fl_we == 1'b0, {req, " R8 single pulse"}, {op_done, fl_we}, 0);
    endtask

    task automatic load_word(input int a, input int d);
        logic [7:0] v;
        int ev = flash_events;
        set_addr(a); set_data(d); keyed(8'h1B);
        lat_exp[a % NL] = d;
        rd(3'd4, v);
        check(op_done == 1'b1 && cpu_stall == 1'b0 && fl_we == 1'b0 && v[0] == 1'b0,
              "R4 latch load done without flash", {op_done, cpu_stall, fl_we, v[0]}, 4'b1000);
        @(negedge clk);
        check(flash_events == ev, "R4 no flash activity on latch load", flash_events, ev);
    endtask

    task automatic block_write(input int a, input int d, input string req);
        int base = a & ~(NL - 1);
        int bad = 0;
        int first = 0;
        set_addr(a); set_data(d); keyed(8'h13);
        lat_exp[a % NL] = d;
        run_long(req, 1'b0, base);
        for (int j = 0; j < NL; j++)
            if (int'(cap_data[j*WW +: WW]) != lat_exp[j]) begin
                if (bad == 0) first = j;
                bad++;
            end
        check(bad == 0, {req, " R5 latch image"}, int'(cap_data[first*WW +: WW]), lat_exp[first]);
        for (int j = 0; j < NL; j++) begin
            exp_mem[base + j] = lat_exp[j];
            lat_exp[j] = 'h3FFF;
        end
        cmp_mem(req);
    endtask

    task automatic exp_erase(input int a);
        int base = a & ~(ROWW - 1);
        for (int j = 0; j < ROWW; j++) exp_mem[base + j] = 'h3FFF;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 0x0 expected 0x1 (run did not finish)");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int ev;
        for (int i = 0; i < 1024; i++) begin
            mem[i] = (i * 113 + 7) & 'h3FFF;
            exp_mem[i] = mem[i];
        end
        for (int j = 0; j < NL; j++) lat_exp[j] = 'h3FFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values of every register and output.
        for (int s = 0; s < 6; s++) begin
            rd(3'(s), v);
            check(v == 8'h00, "R1 register reset value", v, 0);
        end
        check(cpu_stall == 0 && op_done == 0 && fl_we == 0, "R1 outputs idle after reset",
              {cpu_stall, op_done, fl_we}, 0);

        // R7, R8: row erase of the row holding 0x4A.
        set_addr('h4A);
        keyed(8'h17);
        run_long("R7 erase", 1'b1, 'h40);
        exp_erase('h4A);
        cmp_mem("R7 erase row contents");

        // R4, R5: seven latch-only loads at even offsets, final word at 0x4E.
        ev = flash_events;
        for (int k = 0; k < 7; k++) load_word('h40 + 2 * k, 'h100 * k + 'h21);
        check(flash_events == ev, "R4 latch-only loads leave flash alone", flash_events, ev);
        cmp_mem("R4 array unchanged after latch loads");
        block_write('h4E, 'h2ABC, "R5 eight-word block");

        // R6: a second write that loads one latch sees ones elsewhere.
        block_write('h55, 'h1234, "R6 latches reset after commit");

        // R5, R6: sweep every latch index with a single loaded word.
        for (int idx = 0; idx < NL; idx++)
            block_write('h100 + NL * idx + idx, idx * 'h111 + 1, "R5 index sweep");

        // R2: broken key sequences are ignored and flag an error.
        set_addr('h200); set_data('h0777);
        for (int p = 0; p < 5; p++) begin
            ev = flash_events;
            case (p)
                0: begin wr(3'd5, 8'h55); wr(3'd2, 8'h77); wr(3'd5, 8'hAA); end
                1: begin wr(3'd5, 8'h55); end
                2: begin wr(3'd5, 8'h55); wr(3'd5, 8'hAB); end
                3: begin end
                default: begin wr(3'd5, 8'h55); wr(3'd5, 8'hAA); wr(3'd0, 8'h00); end
            endcase
            wr(3'd4, 8'h13);
            begin
                int seen = 0;
                for (int c = 0; c < P + 6; c++) begin
                    if (op_done || cpu_stall || fl_we) seen++;
                    @(negedge clk);
                end
                check(seen == 0, "R2 broken key starts nothing", seen, 0);
            end
            rd(3'd4, v);
            check(v[5] == 1'b1 && v[0] == 1'b0, "R2 key error flag set", v, 8'h32);
            check(flash_events == ev, "R2 broken key no flash write", flash_events, ev);
        end
        cmp_mem("R2 array unchanged after broken keys");

        // R2: an accepted start clears the flag (latch load at 0x200).
        load_word('h200, 'h2AAA);
        rd(3'd4, v);
        check(v[5] == 1'b0, "R2 key error cleared by accepted start", v[5], 0);

        // R3: keyed starts without write enable or memory select do nothing.
        set_addr('h201); set_data('h0555);
        for (int q = 0; q < 2; q++) begin
            keyed(q == 0 ? 8'h11 : 8'h03);
            begin
                int seen = 0;
                for (int c = 0; c < P + 6; c++) begin
                    if (op_done || cpu_stall || fl_we) seen++;
                    @(negedge clk);
                end
                check(seen == 0, "R3 ignored start has no effect", seen, 0);
            end
            rd(3'd4, v);
            check(v[5] == 1'b0 && v[0] == 1'b0, "R3 no error and start clear", v, 0);
        end
        // Latch image still holds only the keyed 0x200 load plus this word.
        block_write('h201, 'h0555, "R3 latches undisturbed");

        // R9: writes during an erase are dropped.
        set_addr('h3E5); set_data('h0123);
        keyed(8'h17);
        repeat (3) @(negedge clk);
        wr(3'd0, 8'h77);
        wr(3'd2, 8'h11);
        begin
            int guard = 0;
            while (!op_done && guard < 100) begin guard++; @(negedge clk); end
        end
        #1;
        check(fl_erase == 1'b1 && int'(fl_addr) == 'h3E0, "R9 erase still ran", int'(fl_addr), 'h3E0);
        exp_erase('h3E5);
        rd(3'd0, v); check(v == 8'hE5, "R9 address low unchanged", v, 'hE5);
        rd(3'd1, v); check(v == 8'h03, "R9 address high unchanged", v, 3);
        rd(3'd2, v); check(v == 8'h23, "R9 data low unchanged", v, 'h23);
        @(negedge clk);
        cmp_mem("R9 erase row contents");
        rd(3'd5, v);
        check(v == 8'h00, "R1 key register reads zero", v, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule